// File: doc/BRIEF.md
# Five-Byte Command Frame Decoder

This block turns a byte stream into fixed-length command frames. The first byte of a frame is an opcode. The next four bytes form a 32-bit argument, with the most significant byte first. When the last byte arrives, the block emits a one-cycle frame pulse carrying the opcode and the argument. A zero byte in the opcode slot does not start a frame. It raises a separate stop pulse instead, and the receiver uses that pulse to leave streaming mode.

Behind the frame assembler sits a small set of tuning registers that the recognised opcodes update: centre frequency, sample rate and gain. A gain given by table index is first clamped to the table size. The clamped index is then presented on a port, and the block stores the gain value that the surrounding logic returns on the matching input. The gain curve itself is computed outside the block.

The assembler is a two-state machine. `ST_IDLE` waits for an opcode byte and `ST_ARG` collects argument bytes. The transitions are:
- **opcode-accept**: a nonzero byte in `ST_IDLE` moves to `ST_ARG`.
- **stop-detect**: a zero byte in `ST_IDLE` stays in `ST_IDLE` and pulses stop.
- **arg-collect**: a byte in `ST_ARG` that is not the last argument byte stays in `ST_ARG`.
- **frame-complete**: the last argument byte returns to `ST_IDLE` and pulses frame valid.
- **clear-abort**: `clr` forces `ST_IDLE` from either state.

Top module: `cmd_frame_decoder`

## Requirements
- R1: A frame is 5 accepted bytes: the opcode, then the argument from its most significant byte to its least. `frm_vld` is high for exactly one cycle, in the cycle after the clock edge that accepts the fifth byte. In that cycle `frm_op` and `frm_arg` hold the frame's opcode and argument. Cycles with `byte_vld` low are ignored.
- R2: A byte of value 0x00 accepted in `ST_IDLE` pulses `stop_pls` for one cycle and gives no `frm_vld`. It does not start a frame, so the next nonzero byte is an opcode. A 0x00 byte in an argument position is ordinary data.
- R3: After a complete frame, the next accepted byte is treated as an opcode.
- R4: Opcode 0x01 sets `freq_reg` to `frm_arg + rate_reg` (modulo 2^32). The register changes one cycle after `frm_vld`.
- R5: Opcode 0x02 sets `rate_reg` to the argument and `freq_reg` to twice the argument (the argument plus the new rate). Both change one cycle after `frm_vld`.
- R6: Opcode 0x04 sets `gain_reg` to the argument, a gain in tenths of a decibel. It changes one cycle after `frm_vld`.
- R7: While `frm_vld` is high, `gain_sel_idx` equals min(`frm_arg`, 28), with a table of 29 entries. For opcode 0x0D, `gain_reg` takes the value of `gain_sel_val` from that cycle, one cycle after `frm_vld`.
- R8: Any other nonzero opcode still gives a `frm_vld` pulse but leaves `freq_reg`, `rate_reg` and `gain_reg` unchanged.
- R9: When `clr` is high on a clock edge, any partly received frame is discarded, the byte offered in that cycle is dropped, and no pulse follows. The next accepted byte is an opcode.
- R10: After reset, `frm_vld` and `stop_pls` are low, `freq_reg` = 94,500,000, `rate_reg` = 100,000 and `gain_reg` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous discard of a partly received frame |
| byte_vld | input | 1 | A byte is offered in this cycle |
| byte_data | input | 8 | Offered byte |
| frm_vld | output | 1 | One-cycle pulse when a frame is complete |
| frm_op | output | 8 | Opcode of the completed frame |
| frm_arg | output | 32 | Argument of the completed frame |
| stop_pls | output | 1 | One-cycle pulse when a stop byte is seen |
| gain_sel_idx | output | 5 | Clamped gain table index |
| gain_sel_val | input | 32 | Gain value returned for `gain_sel_idx` |
| freq_reg | output | 32 | Centre-frequency register |
| rate_reg | output | 32 | Sample-rate register |
| gain_reg | output | 32 | Gain register (tenths of a decibel) |

## Verification
On every cycle, the assertions check these properties:
- `frm_vld` and `stop_pls` never rise together.
- A frame pulse always leaves the assembler back in `ST_IDLE`.
- `clr` always empties the assembler.
- A rate command always loads the argument.
- The clamped index always stays inside the table.
- An unknown opcode always leaves the registers untouched.

Only the bench scenarios can show the rest. Byte order must be right across random gaps between bytes. A zero byte must act as a stop only in the opcode slot. The frequency must follow the rate that was current when the command arrived. Opcodes must line up again correctly after a stop or a clear.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ARG  = 1'b1
    } asm_state_t;

    localparam logic [7:0] OP_STOP     = 8'h00;
    localparam logic [7:0] OP_TUNE     = 8'h01;
    localparam logic [7:0] OP_RATE     = 8'h02;
    localparam logic [7:0] OP_GAIN_DB  = 8'h04;
    localparam logic [7:0] OP_GAIN_IDX = 8'h0D;
endpackage

// File: rtl/cfd_assembler.sv
module cfd_assembler
    import cfd_pkg::*;
#(
    parameter int ARG_BYTES = 4,
    localparam int ARG_W = 8 * ARG_BYTES,
    localparam int CNT_W = (ARG_BYTES > 1) ? $clog2(ARG_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    output logic             frm_vld,
    output logic [7:0]       frm_op,
    output logic [ARG_W-1:0] frm_arg,
    output logic             stop_pls
);
    asm_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [7:0]       op_q, op_d;
    logic [ARG_W-1:0] sh_q, sh_d;
    logic             take, last_byte, stop_seen;

    assign take      = byte_vld && !clr;
    assign last_byte = (state_q == ST_ARG) && (cnt_q == CNT_W'(ARG_BYTES - 1));
    assign stop_seen = take && (state_q == ST_IDLE) && (byte_data == OP_STOP);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        op_d    = op_q;
        sh_d    = sh_q;
        if (clr) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (byte_vld) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (byte_data != OP_STOP) begin
                        state_d = ST_ARG;
                        op_d    = byte_data;
                        cnt_d   = '0;
                    end
                end
                ST_ARG: begin
                    sh_d = {sh_q[ARG_W-9:0], byte_data};
                    if (last_byte) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            op_q    <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            op_q    <= op_d;
            sh_q    <= sh_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_vld  <= 1'b0;
            stop_pls <= 1'b0;
            frm_op   <= '0;
            frm_arg  <= '0;
        end else begin
            frm_vld  <= take && last_byte;
            stop_pls <= stop_seen;
            if (take && last_byte) begin
                frm_op  <= op_q;
                frm_arg <= {sh_q[ARG_W-9:0], byte_data};
            end
        end
    end

    // R1 / R3: a completed frame leaves the assembler waiting for an opcode
    a_r3_idle_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |-> state_q == ST_IDLE);
    // R2: stop and frame pulses are exclusive
    a_r2_stop_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pls |-> !frm_vld);
    // R9: clear empties the assembler with no pulse
    a_r9_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == ST_IDLE) && !frm_vld && !stop_pls);
endmodule

// File: rtl/cfd_regfile.sv
module cfd_regfile
    import cfd_pkg::*;
#(
    parameter int          ARG_W        = 32,
    parameter int          GAIN_ENTRIES = 29,
    parameter logic [31:0] FREQ_INIT    = 32'd94_500_000,
    parameter logic [31:0] RATE_INIT    = 32'd100_000,
    parameter logic [31:0] GAIN_INIT    = 32'd0,
    localparam int IDX_W = $clog2(GAIN_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_vld,
    input  logic [7:0]       frm_op,
    input  logic [ARG_W-1:0] frm_arg,
    output logic [IDX_W-1:0] gain_sel_idx,
    input  logic [ARG_W-1:0] gain_sel_val,
    output logic [ARG_W-1:0] freq_reg,
    output logic [ARG_W-1:0] rate_reg,
    output logic [ARG_W-1:0] gain_reg
);
    always_comb begin
        if (frm_arg >= ARG_W'(GAIN_ENTRIES))
            gain_sel_idx = IDX_W'(GAIN_ENTRIES - 1);
        else
            gain_sel_idx = frm_arg[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_reg <= ARG_W'(FREQ_INIT);
            rate_reg <= ARG_W'(RATE_INIT);
            gain_reg <= ARG_W'(GAIN_INIT);
        end else if (frm_vld) begin
            case (frm_op)
                OP_TUNE:     freq_reg <= frm_arg + rate_reg;
                OP_RATE: begin
                    rate_reg <= frm_arg;
                    freq_reg <= frm_arg + frm_arg;
                end
                OP_GAIN_DB:  gain_reg <= frm_arg;
                OP_GAIN_IDX: gain_reg <= gain_sel_val;
                default: ;
            endcase
        end
    end

    // R5: a rate command loads the argument
    a_r5_rate_load: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_op == OP_RATE) |=> rate_reg == $past(frm_arg));
    // R7: the clamped index stays within the table
    a_r7_idx_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |-> gain_sel_idx <= IDX_W'(GAIN_ENTRIES - 1));
    // R8: unknown opcodes leave every register alone
    a_r8_unknown_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_op != OP_TUNE && frm_op != OP_RATE &&
         frm_op != OP_GAIN_DB && frm_op != OP_GAIN_IDX)
        |=> $stable(freq_reg) && $stable(rate_reg) && $stable(gain_reg));
endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder #(
    parameter int          ARG_BYTES    = 4,
    parameter int          GAIN_ENTRIES = 29,
    parameter logic [31:0] FREQ_INIT    = 32'd94_500_000,
    parameter logic [31:0] RATE_INIT    = 32'd100_000,
    parameter logic [31:0] GAIN_INIT    = 32'd0,
    localparam int ARG_W = 8 * ARG_BYTES,
    localparam int IDX_W = $clog2(GAIN_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    output logic             frm_vld,
    output logic [7:0]       frm_op,
    output logic [ARG_W-1:0] frm_arg,
    output logic             stop_pls,
    output logic [IDX_W-1:0] gain_sel_idx,
    input  logic [ARG_W-1:0] gain_sel_val,
    output logic [ARG_W-1:0] freq_reg,
    output logic [ARG_W-1:0] rate_reg,
    output logic [ARG_W-1:0] gain_reg
);
    cfd_assembler #(.ARG_BYTES(ARG_BYTES)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .frm_vld   (frm_vld),
        .frm_op    (frm_op),
        .frm_arg   (frm_arg),
        .stop_pls  (stop_pls)
    );

    cfd_regfile #(
        .ARG_W        (ARG_W),
        .GAIN_ENTRIES (GAIN_ENTRIES),
        .FREQ_INIT    (FREQ_INIT),
        .RATE_INIT    (RATE_INIT),
        .GAIN_INIT    (GAIN_INIT)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .frm_vld      (frm_vld),
        .frm_op       (frm_op),
        .frm_arg      (frm_arg),
        .gain_sel_idx (gain_sel_idx),
        .gain_sel_val (gain_sel_val),
        .freq_reg     (freq_reg),
        .rate_reg     (rate_reg),
        .gain_reg     (gain_reg)
    );
endmodule

// File: tb/test_cmd_frame_decoder.sv
module test_cmd_frame_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        frm_vld, stop_pls;
    logic [7:0]  frm_op;
    logic [31:0] frm_arg, freq_reg, rate_reg, gain_reg, gain_sel_val;
    logic [4:0]  gain_sel_idx;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] m_freq, m_rate, m_gain;

    always #5 clk = ~clk;

    // stand-in gain table supplied by the surroundings
    assign gain_sel_val = 32'(gain_sel_idx) * 32'd37 + 32'd5;

    cmd_frame_decoder i_cmd_frame_decoder (
        .clk(clk), .rst_n(rst_n), .clr(clr), .byte_vld(byte_vld), .byte_data(byte_data),
        .frm_vld(frm_vld), .frm_op(frm_op), .frm_arg(frm_arg), .stop_pls(stop_pls),
        .gain_sel_idx(gain_sel_idx), .gain_sel_val(gain_sel_val),
        .freq_reg(freq_reg), .rate_reg(rate_reg), .gain_reg(gain_reg)
    );

    function automatic logic [31:0] exp_idx(logic [31:0] a);
        return (a >= 32'd29) ? 32'd28 : a;
    endfunction

    function automatic logic [31:0] table_val(logic [31:0] i);
        return i * 32'd37 + 32'd5;
    endfunction

    task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        byte_vld  = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_vld  = 1'b0;
    endtask

    task automatic gap(int mx);
        int g = (mx > 0) ? int'($urandom % (mx + 1)) : 0;
        repeat (g) @(negedge clk);
    endtask

    // sends a frame, checks the pulse (R1) and the register effect one cycle later
    task automatic run_frame(logic [7:0] op, logic [31:0] arg, int mx_gap);
        send_byte(op);
        for (int k = 3; k >= 0; k--) begin
            gap(mx_gap);
            send_byte(arg[8*k +: 8]);
        end
        cmp("R1 frm_vld", 32'(frm_vld), 32'd1);
        cmp("R1 frm_op", 32'(frm_op), 32'(op));
        cmp("R1 frm_arg", frm_arg, arg);
        cmp("R2 no stop with frame", 32'(stop_pls), 32'd0);
        if (op == 8'h0D) cmp("R7 clamp idx", 32'(gain_sel_idx), exp_idx(arg));
        case (op)
            8'h01: m_freq = arg + m_rate;                         // R4
            8'h02: begin m_rate = arg; m_freq = arg + arg; end    // R5
            8'h04: m_gain = arg;                                  // R6
            8'h0D: m_gain = table_val(exp_idx(arg));              // R7
            default: ;                                            // R8
        endcase
        @(negedge clk);
        cmp("R1 single pulse", 32'(frm_vld), 32'd0);
        cmp("R4/R5 freq_reg", freq_reg, m_freq);
        cmp("R5 rate_reg", rate_reg, m_rate);
        cmp("R6/R7/R8 gain_reg", gain_reg, m_gain);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd4242));
        m_freq = 32'd94_500_000; m_rate = 32'd100_000; m_gain = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        cmp("R10 frm_vld", 32'(frm_vld), 32'd0);
        cmp("R10 stop_pls", 32'(stop_pls), 32'd0);
        cmp("R10 freq_reg", freq_reg, 32'd94_500_000);
        cmp("R10 rate_reg", rate_reg, 32'd100_000);
        cmp("R10 gain_reg", gain_reg, 32'd0);

        // directed R4 with reset rate, R3 back to back
        run_frame(8'h01, 32'h0102_0304, 0);
        run_frame(8'h02, 32'd250_000, 0);
        run_frame(8'h01, 32'd1_000_000, 0);
        // R2 zero argument bytes are data
        run_frame(8'h04, 32'h0000_0000, 2);
        run_frame(8'h04, 32'h0000_0100, 1);
        // R7 clamp boundaries
        run_frame(8'h0D, 32'd28, 0);
        run_frame(8'h0D, 32'd29, 0);
        run_frame(8'h0D, 32'hFFFF_FFFF, 0);
        run_frame(8'h0D, 32'd0, 0);
        // R8 unknown opcode
        run_frame(8'h03, 32'hDEAD_BEEF, 0);
        run_frame(8'hFF, 32'h1234_5678, 0);

        // R2 stop byte in opcode slot
        send_byte(8'h00);
        cmp("R2 stop_pls", 32'(stop_pls), 32'd1);
        cmp("R2 no frame on stop", 32'(frm_vld), 32'd0);
        @(negedge clk);
        cmp("R2 stop single pulse", 32'(stop_pls), 32'd0);
        run_frame(8'h04, 32'd77, 0);

        // R9 clear discards partial frame, drops the byte offered with it
        send_byte(8'h04);
        send_byte(8'hAA);
        clr = 1'b1; byte_vld = 1'b1; byte_data = 8'h55;
        @(negedge clk);
        clr = 1'b0; byte_vld = 1'b0;
        cmp("R9 no frame after clear", 32'(frm_vld), 32'd0);
        cmp("R9 no stop after clear", 32'(stop_pls), 32'd0);
        cmp("R9 gain kept", gain_reg, m_gain);
        run_frame(8'h02, 32'd48_000, 0);

        // random frames mixed with stop bytes
        for (int n = 0; n < 300; n++) begin
            int kind = int'($urandom % 6);
            logic [31:0] a = $urandom;
            logic [7:0] op;
            case (kind)
                0: op = 8'h01;
                1: op = 8'h02;
                2: op = 8'h04;
                3: begin op = 8'h0D; if ($urandom % 2 == 0) a = $urandom % 40; end
                4: begin
                    op = 8'(($urandom % 255) + 1);
                    if (op == 8'h01 || op == 8'h02 || op == 8'h04 || op == 8'h0D) op = 8'h80;
                end
                default: op = 8'h00;
            endcase
            if (op == 8'h00) begin
                send_byte(8'h00);
                cmp("R2 random stop", 32'(stop_pls), 32'd1);
                @(negedge clk);
            end else begin
                run_frame(op, a, 3);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule